// File: doc/BRIEF.md
# Wiper Command Decoder and Control

This block sits between a serial-bus front end and the storage manager of a one-time-programmable wiper memory. Each time the front end presents a 4-bit operation code with a 10-bit payload, the block decodes it and acts on its own state: a 10-bit wiper code, a small control register, and a shutdown flag. It also stages the 16-bit word that the next read frame returns.

Operations that touch non-volatile storage are passed to the manager as single-cycle requests. These are saving the wiper into the next free slot, reloading the wiper from the newest saved slot, and fetching an arbitrary slot. Results come back on valid strobes. Two control bits gate what software may do. The wiper write bit, cleared by default, keeps the wiper frozen at its saved value. The program enable bit, also cleared by default, blocks saving. A third bit is read-only and becomes sticky once a save succeeds.

The active-low reset input puts the control state back to its defaults. When reset is released, the block requests a reload, so the wiper comes back to the last saved value.

Top module: `wiper_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low, all three control bits, `shutdown` and `rd_word` are 0. `restore_req` pulses high for one cycle in the cycle after the first clock edge with `rst_n` high.
- R2: Code 1, with the wiper write bit (C1) at 1 and `mem_busy` low, loads `cmd_data` into `wiper` at the next edge. If `restore_valid` arrives in the same cycle, it takes priority.
- R3: Code 1 with C1 at 0 leaves `wiper` unchanged.
- R4: Code 7 writes `cmd_data[1]` into C1 and `cmd_data[0]` into C0. Code 8 stages `rd_word` with C2 at bit 3, 0 at bit 2, C1 at bit 1, C0 at bit 0, and zeros above.
- R5: Code 3 with C0 at 1 and `mem_busy` low pulses `store_req` in the next cycle, with `store_data` equal to the current wiper. With C0 at 0 it issues nothing.
- R6: C2 is set when `store_done` and `store_ok` are high together. After that it is cleared only by reset.
- R7: Code 4 pulses `restore_req`. Any `restore_valid` loads `restore_data` into `wiper`, whatever the value of C1.
- R8: Code 2 stages `{6'b0, wiper}` into `rd_word`. Code 6 stages `{10'b0, last_slot}`. Code 5 pulses `mread_req` with `mread_addr = cmd_data[5:0]`, and a later `mread_valid` stages `{6'b0, mread_data}`. Other codes leave `rd_word` unchanged.
- R9: Code 9 sets `shutdown` to `cmd_data[0]`, where 1 means shut down and 0 means normal.
- R10: Codes 0 and 10 to 15 change nothing visible.
- R11: While `mem_busy` is high, codes 1, 3, 4 and 5 are ignored: no request is issued and `wiper` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release triggers a reload |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Operation code |
| cmd_data | input | 10 | Operation payload |
| wiper | output | 10 | Wiper code |
| shutdown | output | 1 | Shutdown flag |
| rd_word | output | 16 | Word returned by next read frame |
| store_req | output | 1 | Save request pulse |
| store_data | output | 10 | Value to save |
| restore_req | output | 1 | Reload request pulse |
| mread_req | output | 1 | Slot fetch request pulse |
| mread_addr | output | 6 | Slot to fetch |
| mem_busy | input | 1 | Manager busy |
| store_done | input | 1 | Save finished |
| store_ok | input | 1 | Save succeeded (with store_done) |
| restore_valid | input | 1 | Reload data valid |
| restore_data | input | 10 | Reloaded wiper value |
| mread_valid | input | 1 | Fetched slot valid |
| mread_data | input | 10 | Fetched slot contents |
| last_slot | input | 6 | Index of newest saved slot |

## Verification
A wrong control bit is not visible on `wiper` directly. It shows up one command later, as a write that should have been blocked or a save request that should not have been sent. It is also visible within one cycle of a code-8 read. A stale or corrupted wiper shows up on `wiper` one edge after the command. A staging error appears in `rd_word` one edge after the read command, or one edge after the manager's valid strobe. The bench therefore checks all three outputs after every command has settled.

// File: rtl/wiper_cmd_ctrl.sv
module wiper_cmd_ctrl #(
  parameter int WIPER_W = 10,
  parameter int SLOT_W  = 6,
  parameter int WORD_W  = 16,
  parameter int CODE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [CODE_W-1:0]  cmd_code,
  input  logic [WIPER_W-1:0] cmd_data,
  output logic [WIPER_W-1:0] wiper,
  output logic               shutdown,
  output logic [WORD_W-1:0]  rd_word,
  output logic               store_req,
  output logic [WIPER_W-1:0] store_data,
  output logic               restore_req,
  output logic               mread_req,
  output logic [SLOT_W-1:0]  mread_addr,
  input  logic               mem_busy,
  input  logic               store_done,
  input  logic               store_ok,
  input  logic               restore_valid,
  input  logic [WIPER_W-1:0] restore_data,
  input  logic               mread_valid,
  input  logic [WIPER_W-1:0] mread_data,
  input  logic [SLOT_W-1:0]  last_slot
);
  localparam logic [CODE_W-1:0] OP_WRITE = CODE_W'(1);
  localparam logic [CODE_W-1:0] OP_RDWIP = CODE_W'(2);
  localparam logic [CODE_W-1:0] OP_STORE = CODE_W'(3);
  localparam logic [CODE_W-1:0] OP_RELOAD = CODE_W'(4);
  localparam logic [CODE_W-1:0] OP_RDSLOT = CODE_W'(5);
  localparam logic [CODE_W-1:0] OP_RDLAST = CODE_W'(6);
  localparam logic [CODE_W-1:0] OP_SETCTL = CODE_W'(7);
  localparam logic [CODE_W-1:0] OP_RDCTL = CODE_W'(8);
  localparam logic [CODE_W-1:0] OP_SHDN  = CODE_W'(9);
  localparam int PAD_W = WORD_W - WIPER_W;
  localparam int PAD_S = WORD_W - SLOT_W;

  logic prog_en, wr_en, stored_ok, boot;
  logic mem_free;
  logic do_write, do_store, do_reload, do_rdslot;

  assign mem_free  = cmd_valid && !mem_busy;
  assign do_write  = mem_free && cmd_code == OP_WRITE && wr_en;
  assign do_store  = mem_free && cmd_code == OP_STORE && prog_en;
  assign do_reload = mem_free && cmd_code == OP_RELOAD;
  assign do_rdslot = mem_free && cmd_code == OP_RDSLOT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_en     <= 1'b0;
      wr_en       <= 1'b0;
      stored_ok   <= 1'b0;
      shutdown    <= 1'b0;
      rd_word     <= '0;
      store_req   <= 1'b0;
      store_data  <= '0;
      restore_req <= 1'b0;
      mread_req   <= 1'b0;
      mread_addr  <= '0;
      boot        <= 1'b1;
    end else begin
      boot        <= 1'b0;
      store_req   <= do_store;
      restore_req <= do_reload || boot;
      mread_req   <= do_rdslot;
      if (do_store)  store_data <= wiper;
      if (do_rdslot) mread_addr <= cmd_data[SLOT_W-1:0];
      if (store_done && store_ok) stored_ok <= 1'b1;
      if (cmd_valid) begin
        case (cmd_code)
          OP_RDWIP:  rd_word <= {{PAD_W{1'b0}}, wiper};
          OP_RDLAST: rd_word <= {{PAD_S{1'b0}}, last_slot};
          OP_RDCTL:  rd_word <= {{(WORD_W-4){1'b0}}, stored_ok, 1'b0, wr_en, prog_en};
          OP_SETCTL: begin
            wr_en   <= cmd_data[1];
            prog_en <= cmd_data[0];
          end
          OP_SHDN:   shutdown <= cmd_data[0];
          default: ;
        endcase
      end
      if (mread_valid) rd_word <= {{PAD_W{1'b0}}, mread_data};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             wiper <= '0;
    else if (restore_valid) wiper <= restore_data;
    else if (do_write)      wiper <= cmd_data;
  end
endmodule

module wiper_cmd_ctrl_chk #(
  parameter int WIPER_W = 10,
  parameter int SLOT_W  = 6,
  parameter int WORD_W  = 16,
  parameter int CODE_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [CODE_W-1:0]  cmd_code,
  input logic [WIPER_W-1:0] cmd_data,
  input logic [WIPER_W-1:0] wiper,
  input logic               shutdown,
  input logic [WORD_W-1:0]  rd_word,
  input logic               store_req,
  input logic [WIPER_W-1:0] store_data,
  input logic               restore_req,
  input logic               mread_req,
  input logic               mem_busy,
  input logic               restore_valid,
  input logic [WIPER_W-1:0] restore_data,
  input logic               mread_valid,
  input logic               wr_en,
  input logic               prog_en,
  input logic               stored_ok
);
  p_boot_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> restore_req);
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CODE_W'(1) && wr_en && !mem_busy && !restore_valid)
    |=> wiper == $past(cmd_data));
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CODE_W'(1) && !wr_en && !restore_valid) |=> $stable(wiper));
  p_ctl_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CODE_W'(8) && !mread_valid)
    |=> rd_word[WORD_W-1:4] == '0 && rd_word[2] == 1'b0);
  p_store_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CODE_W'(3) && !prog_en) |=> !store_req);
  p_store_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> store_data == $past(wiper));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(stored_ok));
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> wiper == $past(restore_data));
  p_shdn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CODE_W'(9)) |=> shutdown == $past(cmd_data[0]));
  p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == '0 || cmd_code >= CODE_W'(10)) && !restore_valid && !mread_valid)
    |=> $stable(wiper) && $stable(shutdown) && $stable(rd_word));
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && mem_busy && (cmd_code == CODE_W'(3) || cmd_code == CODE_W'(5)))
    |=> !store_req && !mread_req);
endmodule

bind wiper_cmd_ctrl wiper_cmd_ctrl_chk #(
  .WIPER_W(WIPER_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_data(cmd_data), .wiper(wiper), .shutdown(shutdown), .rd_word(rd_word),
  .store_req(store_req), .store_data(store_data), .restore_req(restore_req),
  .mread_req(mread_req), .mem_busy(mem_busy), .restore_valid(restore_valid),
  .restore_data(restore_data), .mread_valid(mread_valid), .wr_en(wr_en),
  .prog_en(prog_en), .stored_ok(stored_ok)
);

// File: tb/wiper_cmd_ctrl_tb.sv
module wiper_cmd_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [9:0] cmd_data = '0;
  logic [9:0] wiper, store_data;
  logic shutdown, store_req, restore_req, mread_req;
  logic [15:0] rd_word;
  logic [5:0] mread_addr;
  logic mem_busy = 1'b0, store_done = 1'b0, store_ok = 1'b0;
  logic restore_valid = 1'b0, mread_valid = 1'b0;
  logic [9:0] restore_data = '0, mread_data = '0;
  logic [5:0] last_slot = '0;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wiper_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .wiper(wiper), .shutdown(shutdown), .rd_word(rd_word),
    .store_req(store_req), .store_data(store_data), .restore_req(restore_req),
    .mread_req(mread_req), .mread_addr(mread_addr), .mem_busy(mem_busy),
    .store_done(store_done), .store_ok(store_ok), .restore_valid(restore_valid),
    .restore_data(restore_data), .mread_valid(mread_valid), .mread_data(mread_data),
    .last_slot(last_slot)
  );

  // storage manager model
  logic [9:0] mem [64];
  logic [1:0] op = '0;
  logic [2:0] cnt = '0;
  logic [9:0] sdat = '0;
  logic [5:0] raddr = '0;
  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always @(posedge clk) begin
    store_done <= 1'b0; store_ok <= 1'b0; restore_valid <= 1'b0; mread_valid <= 1'b0;
    if (!mem_busy) begin
      if (store_req)        begin mem_busy <= 1'b1; op <= 2'd1; cnt <= 3'd4; sdat <= store_data; end
      else if (restore_req) begin mem_busy <= 1'b1; op <= 2'd2; cnt <= 3'd4; end
      else if (mread_req)   begin mem_busy <= 1'b1; op <= 2'd3; cnt <= 3'd4; raddr <= mread_addr; end
    end else if (cnt != 0) cnt <= cnt - 3'd1;
    else begin
      mem_busy <= 1'b0;
      case (op)
        2'd1: begin
          store_done <= 1'b1;
          if (last_slot < 6'd50) begin
            mem[last_slot + 6'd1] <= sdat; last_slot <= last_slot + 6'd1; store_ok <= 1'b1;
          end
        end
        2'd2: begin restore_valid <= 1'b1; restore_data <= mem[last_slot]; end
        2'd3: begin mread_valid <= 1'b1; mread_data <= mem[raddr]; end
        default: ;
      endcase
    end
  end

  // reference model
  logic [9:0] r_wip = '0;
  logic r_c0 = 0, r_c1 = 0, r_c2 = 0, r_sd = 0;
  logic [15:0] r_rd = '0;
  logic [9:0] r_mem [64];
  int r_used = 0;
  initial for (int i = 0; i < 64; i++) r_mem[i] = '0;

  function automatic logic [15:0] ctl_word(logic c2, logic c1, logic c0);
    return {12'b0, c2, 1'b0, c1, c0};
  endfunction

  task automatic ref_apply(input logic [3:0] c, input logic [9:0] d);
    case (c)
      4'd1: if (r_c1) r_wip = d;
      4'd2: r_rd = {6'b0, r_wip};
      4'd3: if (r_c0 && r_used < 50) begin r_used++; r_mem[r_used] = r_wip; r_c2 = 1; end
      4'd4: r_wip = r_mem[r_used];
      4'd5: r_rd = {6'b0, r_mem[d[5:0]]};
      4'd6: r_rd = 16'(r_used);
      4'd7: begin r_c1 = d[1]; r_c0 = d[0]; end
      4'd8: r_rd = ctl_word(r_c2, r_c1, r_c0);
      4'd9: r_sd = d[0];
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [9:0] d);
    @(negedge clk); cmd_valid = 1; cmd_code = c; cmd_data = d;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic do_cmd(input logic [3:0] c, input logic [9:0] d);
    issue(c, d);
    ref_apply(c, d);
    repeat (10) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    check({req, " wiper"}, {6'b0, wiper}, {6'b0, r_wip});
    check({req, " shutdown"}, {15'b0, shutdown}, {15'b0, r_sd});
    check({req, " rd_word"}, rd_word, r_rd);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 rd_word in reset", rd_word, 16'h0);
    check("R1 shutdown in reset", {15'b0, shutdown}, 16'h0);
    rst_n = 1;
    r_c0 = 0; r_c1 = 0; r_c2 = 0; r_sd = 0; r_rd = '0; r_wip = r_mem[r_used];
    repeat (12) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [9:0] keep;
  int unused_seed;
  initial begin
    unused_seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    hw_reset();
    check_all("R1 after boot reload");
    do_cmd(4'd8, 10'h0); check("R1 ctl defaults", rd_word, 16'h0);
    do_cmd(4'd1, 10'h2AA); check_all("R3 frozen write");
    do_cmd(4'd3, 10'h0); do_cmd(4'd8, 10'h0); check("R5 store with C0=0, R6 C2 clear", rd_word, 16'h0);
    do_cmd(4'd7, 10'h3FE); do_cmd(4'd8, 10'h0); check("R4 ctl readback", rd_word, 16'h0002);
    do_cmd(4'd1, 10'h3FF); check_all("R2 write enabled");
    do_cmd(4'd7, 10'h003); do_cmd(4'd3, 10'h0);
    do_cmd(4'd8, 10'h0); check("R6 C2 set after store", rd_word, 16'h000B);
    do_cmd(4'd6, 10'h0); check("R8 last slot", rd_word, 16'h0001);
    do_cmd(4'd1, 10'h011); do_cmd(4'd2, 10'h0); check_all("R8 wiper readback");
    do_cmd(4'd4, 10'h0); check_all("R7 reload from last slot");
    do_cmd(4'd5, 10'h001); check_all("R8 slot read");
    do_cmd(4'd9, 10'h001); check_all("R9 shutdown on");
    do_cmd(4'd0, 10'h3FF); check_all("R10 nop code 0");
    do_cmd(4'd13, 10'h3FF); check_all("R10 nop code 13");
    do_cmd(4'd7, 10'h002); do_cmd(4'd8, 10'h0); check("R6 C2 sticky", rd_word, 16'h000A);
    do_cmd(4'd3, 10'h0); check("R5 store blocked slot count", 16'(last_slot), 16'h0001);
    do_cmd(4'd7, 10'h003);
    // R11: command arrives while manager busy with a save
    keep = r_wip;
    issue(4'd3, 10'h0); ref_apply(4'd3, 10'h0);
    issue(4'd1, 10'h155);
    repeat (10) @(negedge clk);
    check("R11 write ignored while busy", {6'b0, wiper}, {6'b0, keep});
    check("R11 store completed", 16'(last_slot), 16'(r_used));
    for (int n = 0; n < 300; n++) begin
      logic [3:0] c; logic [9:0] d;
      c = 4'($urandom % 16);
      d = 10'($urandom);
      if (c == 4'd3 && r_used >= 48) c = 4'd2;
      do_cmd(c, d);
      check_all($sformatf("R2/R4/R7/R8/R9/R10 random code %0d", c));
    end
    hw_reset();
    check_all("R1 hw reset reloads last stored");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule